// File: doc/BRIEF.md
# Write-Completion Status Responder

This block decides what a byte-wide memory returns on a read while its internal write or erase cycle runs. A controller pulses `cycle_start_i` on the strobe edge that launches the cycle. It marks erase cycles on `cycle_erase_i`, holds `busy_i` high until the cycle ends, and offers the byte loaded last on `last_byte_i`. While the cycle runs, the array data is replaced by a status byte. Bit 7 carries the inverted copy of bit 7 of the latched byte (the polling bit). Bit 6 flips on every read (the toggle bit). All other bits read zero.

When `busy_i` drops, a settle window of `SETTLE_CYC` clocks follows. In this window only bit 7 carries meaning: it reports the true data. Afterwards the block passes array data straight through again. In an erase cycle the polling bit means nothing, so it reads 0 while busy. At the end of an erase it reads 1, which is the erased value. A new start pulse at any time restarts the cycle and re-arms the toggle.

Top module: `wcs_status_responder`

## Requirements
- R1: While rst_ni is low, status_o and settle_o are 0 and rd_data_o equals array_data_i.
- R2: Outside a status phase, rd_data_o equals array_data_i. busy_i and rd_strobe_i without a start pulse have no effect.
- R3: From the clock after a start pulse with cycle_erase_i = 0 until busy_i falls, rd_data_o[7] is the inverse of last_byte_i[7] sampled at the start pulse. Later changes to last_byte_i are ignored.
- R4: In the busy phase, rd_data_o[6] is 1 until the first read strobe. Each strobe flips it at the next clock, and cycles without a strobe leave it unchanged.
- R5: In the busy and settle phases, every bit of rd_data_o other than bits 7 and 6 reads 0.
- R6: In an erase cycle (cycle_erase_i = 1 at the start pulse), rd_data_o[7] reads 0 in the busy phase and the toggle bit behaves as in R4.
- R7: From the clock after busy_i is seen low in the busy phase, settle_o stays high for exactly SETTLE_CYC cycles. During that window rd_data_o[7] is the true data (the latched bit 7, or 1 for erase) and rd_data_o[6] is 0. Afterwards the block returns to pass-through.
- R8: A start pulse in the busy or settle phase restarts the busy phase, latches the new byte and sets the toggle back to 1. A read in the same cycle as a start pulse is served by the phase in force before the start.
- R9: status_o is low in the cycle of a start pulse taken from idle. It is high from the next cycle until the settle window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cycle_start_i | input | 1 | One-cycle pulse: internal cycle launched |
| cycle_erase_i | input | 1 | Qualifies cycle_start_i: 1 = erase cycle, 0 = page write |
| busy_i | input | 1 | Write controller busy flag |
| last_byte_i | input | DATA_W | Last byte loaded, latched at start |
| rd_strobe_i | input | 1 | One-cycle pulse per host read |
| array_data_i | input | DATA_W | Array read data for pass-through |
| rd_data_o | output | DATA_W | Byte returned to the host |
| status_o | output | 1 | Status byte replaces array data |
| settle_o | output | 1 | Post-completion settle window active |

## Verification
A read can arrive in the same cycle as a start pulse. Here the toggle flip and the toggle restart compete, and the restart has to win while the read is still answered from the previous phase. The bench lands a read strobe on every start pulse, from idle and from the middle of a busy phase after several flips. It expects pass-through data or the old status byte in that cycle, and a toggle of 1 on the next cycle. A read in the cycle where busy_i falls is handled the same way: that read must return the busy status byte, and the settle window begins only on the next cycle.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;
endpackage

// File: rtl/wcs_phase_fsm.sv
module wcs_phase_fsm
  import wcs_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 50
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   busy_i,
  output phase_e phase_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_BUSY;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_BUSY: if (!busy_i) begin
          phase_q <= PH_SETTLE;
          cnt_q   <= CW'(SETTLE_CYC - 1);
        end
        PH_SETTLE: if (cnt_q == '0) phase_q <= PH_IDLE;
                   else             cnt_q   <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/wcs_cycle_latch.sv
module wcs_cycle_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              erase_o,
  output logic [DATA_W-1:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_o <= 1'b0;
      byte_o  <= '0;
    end else if (start_i) begin
      erase_o <= erase_i;
      byte_o  <= byte_i;
    end
  end
endmodule

// File: rtl/wcs_toggle_gen.sv
module wcs_toggle_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic rd_i,
  output logic tog_o
);
  // start re-arms and wins over a coincident read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tog_o <= 1'b1;
    else if (start_i)          tog_o <= 1'b1;
    else if (active_i && rd_i) tog_o <= ~tog_o;
  end
endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
  import wcs_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6
) (
  input  phase_e            phase_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] held_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] data_o
);
  logic in_busy, in_settle;
  assign in_busy   = (phase_i == PH_BUSY);
  assign in_settle = (phase_i == PH_SETTLE);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign data_o[b] = in_busy   ? (erase_i ? 1'b0 : ~held_i[b]) :
                         in_settle ? (erase_i ? 1'b1 :  held_i[b]) :
                                     array_i[b];
    end else if (b == TOGGLE_BIT) begin : g_tog
      assign data_o[b] = in_busy   ? tog_i :
                         in_settle ? 1'b0  : array_i[b];
    end else begin : g_fill
      assign data_o[b] = (in_busy || in_settle) ? 1'b0 : array_i[b];
    end
  end
endmodule

// File: rtl/wcs_status_responder.sv
module wcs_status_responder
  import wcs_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6,
  parameter int unsigned SETTLE_CYC = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_start_i,
  input  logic              cycle_erase_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              status_o,
  output logic              settle_o
);
  phase_e            phase;
  logic              erase_q;
  logic [DATA_W-1:0] held_q;
  logic              tog_q;

  wcs_phase_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cycle_start_i),
    .busy_i  (busy_i),
    .phase_o (phase)
  );

  wcs_cycle_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cycle_start_i),
    .erase_i (cycle_erase_i),
    .byte_i  (last_byte_i),
    .erase_o (erase_q),
    .byte_o  (held_q)
  );

  wcs_toggle_gen u_tog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cycle_start_i),
    .active_i (phase == PH_BUSY),
    .rd_i     (rd_strobe_i),
    .tog_o    (tog_q)
  );

  wcs_status_mux #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) u_mux (
    .phase_i (phase),
    .erase_i (erase_q),
    .held_i  (held_q),
    .tog_i   (tog_q),
    .array_i (array_data_i),
    .data_o  (rd_data_o)
  );

  assign status_o = (phase != PH_IDLE);
  assign settle_o = (phase == PH_SETTLE);
endmodule

// File: rtl/wcs_status_responder_chk.sv
module wcs_status_responder_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6,
  parameter int unsigned SETTLE_CYC = 50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cycle_start_i,
  input logic              cycle_erase_i,
  input logic              busy_i,
  input logic [DATA_W-1:0] last_byte_i,
  input logic              rd_strobe_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              status_o,
  input logic              settle_o
);
  localparam logic [DATA_W-1:0] KEEP =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

  logic busy_ph;
  assign busy_ph = status_o && !settle_o;

  int unsigned run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= 0;
    else if (settle_o) run_q <= run_q + 1;
    else               run_q <= 0;
  end

  a_r2_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o |-> rd_data_o == array_data_i);

  a_r3_poll_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_i && !cycle_erase_i) |=>
      rd_data_o[POLL_BIT] == !$past(last_byte_i[POLL_BIT]));

  a_r4_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_ph && busy_i && rd_strobe_i && !cycle_start_i) |=>
      rd_data_o[TOGGLE_BIT] != $past(rd_data_o[TOGGLE_BIT]));

  a_r4_toggle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_ph && busy_i && !rd_strobe_i && !cycle_start_i) |=>
      $stable(rd_data_o[TOGGLE_BIT]));

  a_r5_filler_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> (rd_data_o & ~KEEP) == '0);

  a_r6_erase_poll_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_i && cycle_erase_i) |=> rd_data_o[POLL_BIT] == 1'b0);

  a_r7_enter_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_ph && !busy_i && !cycle_start_i) |=> settle_o);

  a_r7_settle_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |-> run_q < SETTLE_CYC);

  a_r8_restart_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_i |=> rd_data_o[TOGGLE_BIT] == 1'b1);

  a_r9_start_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_i |=> status_o && !settle_o);
endmodule

bind wcs_status_responder wcs_status_responder_chk #(
  .DATA_W     (DATA_W),
  .POLL_BIT   (POLL_BIT),
  .TOGGLE_BIT (TOGGLE_BIT),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cycle_start_i (cycle_start_i),
  .cycle_erase_i (cycle_erase_i),
  .busy_i        (busy_i),
  .last_byte_i   (last_byte_i),
  .rd_strobe_i   (rd_strobe_i),
  .array_data_i  (array_data_i),
  .rd_data_o     (rd_data_o),
  .status_o      (status_o),
  .settle_o      (settle_o)
);

// File: tb/wcs_status_responder_tb.sv
module wcs_status_responder_tb;
  localparam int SETTLE = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0, erase = 1'b0, busy = 1'b0, strobe = 1'b0;
  logic [7:0] lastb = 8'h00, arr = 8'h00;
  logic [7:0] rd_data;
  logic       status, settle;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  wcs_status_responder #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cycle_start_i (start),
    .cycle_erase_i (erase),
    .busy_i        (busy),
    .last_byte_i   (lastb),
    .rd_strobe_i   (strobe),
    .array_data_i  (arr),
    .rd_data_o     (rd_data),
    .status_o      (status),
    .settle_o      (settle)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drv(input logic s, input logic e, input logic b, input logic r,
                     input logic [7:0] lb, input logic [7:0] a);
    @(negedge clk_i);
    start = s; erase = e; busy = b; strobe = r; lastb = lb; arr = a;
    #1;
  endtask

  function automatic logic [7:0] exp_busy(input logic [7:0] b, input logic er, input logic t);
    logic [7:0] v = 8'h00;
    v[7] = er ? 1'b0 : ~b[7];
    v[6] = t;
    return v;
  endfunction

  function automatic logic [7:0] exp_settle(input logic [7:0] b, input logic er);
    logic [7:0] v = 8'h00;
    v[7] = er ? 1'b1 : b[7];
    return v;
  endfunction

  // one full cycle from idle; optional restart mid-busy or mid-settle
  task automatic run_cycle(input logic [7:0] b0, input logic er, input int nrd,
                           input bit re_busy, input bit re_settle);
    logic [7:0] b = b0;
    logic       tog;
    string      tag = er ? "R6" : "R3";
    drv(1, er, 1, 1, b, ~b);
    chk(rd_data == ~b && !status, "R8/R9 start from idle serves pass-through", rd_data, ~b);
    tog = 1'b1;
    drv(0, 0, 1, 0, ~b, 8'h5A);
    chk(status && !settle, "R9 status after start", {6'b0, status, settle}, 8'h02);
    chk(rd_data == exp_busy(b, er, tog), tag, rd_data, exp_busy(b, er, tog));
    for (int k = 0; k < nrd; k++) begin
      drv(0, 0, 1, 1, 8'hFF, 8'h5A);
      chk(rd_data == exp_busy(b, er, tog), "R4 read", rd_data, exp_busy(b, er, tog));
      tog = ~tog;
      drv(0, 0, 1, 0, 8'h00, 8'hA5);
      chk(rd_data == exp_busy(b, er, tog), "R4 hold/R5", rd_data, exp_busy(b, er, tog));
    end
    if (re_busy) begin
      logic [7:0] nb = b ^ 8'h81;
      drv(1, er, 1, 1, nb, 8'h00);
      chk(rd_data == exp_busy(b, er, tog), "R8 coincident read old phase", rd_data, exp_busy(b, er, tog));
      b = nb; tog = 1'b1;
      drv(0, 0, 1, 0, 8'h00, 8'h00);
      chk(rd_data == exp_busy(b, er, tog), "R8 restart busy", rd_data, exp_busy(b, er, tog));
    end
    drv(0, 0, 0, 1, 8'h00, 8'h33);
    chk(rd_data == exp_busy(b, er, tog) && !settle, "R7 read at busy fall", rd_data, exp_busy(b, er, tog));
    for (int s = 0; s < SETTLE; s++) begin
      if (re_settle && s == 2) begin
        drv(1, er, 1, 1, b, 8'h33);
        chk(rd_data == exp_settle(b, er) && settle, "R8 start in settle", rd_data, exp_settle(b, er));
        drv(0, 0, 1, 0, 8'h00, 8'h33);
        chk(rd_data == exp_busy(b, er, 1'b1) && !settle, "R8 restart from settle", rd_data, exp_busy(b, er, 1'b1));
        drv(0, 0, 0, 0, 8'h00, 8'h33);
        s = -1;
        re_settle = 1'b0;
      end else begin
        drv(0, 0, 0, logic'(s % 2), 8'h00, 8'h33);
        chk(settle && status && rd_data == exp_settle(b, er), "R7 settle window",
            rd_data, exp_settle(b, er));
      end
    end
    drv(0, 0, 0, 1, 8'h00, b ^ 8'h3C);
    chk(!status && !settle && rd_data == (b ^ 8'h3C), "R7 exit to pass-through", rd_data, b ^ 8'h3C);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    drv(1, 0, 1, 1, 8'hC3, 8'h96);
    chk(!status && !settle && rd_data == 8'h96, "R1 reset", rd_data, 8'h96);
    drv(0, 0, 1, 0, 8'hC3, 8'h69);
    chk(!status && rd_data == 8'h69, "R1 reset", rd_data, 8'h69);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2: busy and reads without start leave pass-through
    for (int i = 0; i < 8; i++) begin
      drv(0, 0, 1, logic'(i % 2), 8'hFF, 8'(i * 37));
      chk(!status && rd_data == 8'(i * 37), "R2 no start", rd_data, 8'(i * 37));
    end

    for (int v = 0; v < 256; v++)
      run_cycle(8'(v), 1'b0, v % 4 + 1, (v % 16) == 5, (v % 32) == 11);
    for (int v = 0; v < 256; v += 29)
      run_cycle(8'(v), 1'b1, v % 5 + 1, (v % 2) == 1, (v % 3) == 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule